// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt output of a real-time clock and the status flag behind it. It runs from a 32.768 kHz tick enable. It owns the sub-second prescaler, which is a free-running binary counter that wraps once per second. It also issues the one-cycle strobe that advances the external seconds counter. The calendar counters feed back three boundary qualifiers. Each one is high while the next second increment will cross a minute, an hour or a month boundary.

A three-bit mode code, loaded through a write strobe, selects the output:

- **Idle or forced low.** The output can be held idle (high) or forced low.
- **Square wave.** The output can run as a 2 Hz or 1 Hz 50% square wave. The second increment then trails the falling edge by a fixed number of ticks.
- **Level interrupt.** The output can act as a level interrupt once per second, minute, hour or month. It falls together with the flag at the selected increment and stays low until software clears the flag.

A write to the seconds counter restarts the sub-second chain. A signed trim strobe lengthens or shortens one low phase by a small number of ticks, which serves the oscillator adjustment.

Top module: `rtc_tick_irq`

## Requirements
- R1: After reset the mode code is 000, `irq_n` is 1, `flag` is 0 and `sec_inc` is 0.
- R2: With mode 000, `irq_n` stays 1. With mode 001, `irq_n` stays 0. In both modes `flag` is never set.
- R3: With mode 010, `irq_n` is a square wave. It is low for 2^(PRE_W-2) ticks and then high for 2^(PRE_W-2) ticks.
- R4: With mode 011, `irq_n` is a square wave. It is low for 2^(PRE_W-1) ticks and then high for 2^(PRE_W-1) ticks.
- R5: `sec_inc` is a one-cycle strobe issued once per 2^PRE_W ticks. It rises exactly SEC_PHASE ticks after a falling edge of the 1 Hz wave.
- R6: With mode 100, `flag` rises and `irq_n` falls in the same cycle as every `sec_inc` strobe.
- R7: With modes 101, 110 and 111, the flag is set at a `sec_inc` strobe only if the qualifier for that mode is high in the cycle the strobe is generated. The qualifiers are `min_edge` for 101, `hour_edge` for 110 and `month_edge` for 111. The other qualifiers have no effect.
- R8: A `flag_wr` cycle with `flag_wdata`=0 clears the flag, and in level modes `irq_n` returns to 1 on the next cycle. A `flag_wr` cycle with `flag_wdata`=1 leaves the flag unchanged.
- R9: A clearing write in the same cycle as a selected event leaves the flag set.
- R10: A `sec_wr` pulse loads the prescaler with SEC_PHASE. The outcome is:
  - In the square-wave modes, `irq_n` reads 0 on the next cycle.
  - No `sec_inc` appears on the cycle after the write.
  - The next `sec_inc` appears exactly 2^PRE_W ticks after the write.
- R11: An `adj_stb` captures a signed `adj_delta`. The next time the prescaler passes 2^(PRE_W-3), the step is 1+delta, and this happens once. The 1 Hz low phase therefore lasts 2^(PRE_W-1)-delta ticks. The delta must keep the count within the low phase.
- R12: A `mode_wr` pulse loads `mode_wdata`, and the new mode drives `irq_n` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz tick enable |
| mode_wr | input | 1 | Mode code write strobe |
| mode_wdata | input | 3 | Mode code to load |
| sec_wr | input | 1 | Seconds counter write strobe |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data (only 0 acts) |
| min_edge | input | 1 | Next increment crosses a minute boundary |
| hour_edge | input | 1 | Next increment crosses an hour boundary |
| month_edge | input | 1 | Next increment crosses a month boundary |
| adj_stb | input | 1 | Trim request strobe |
| adj_delta | input | ADJ_W | Signed trim in ticks |
| irq_n | output | 1 | Active-low interrupt / square wave |
| flag | output | 1 | Interrupt status flag |
| sec_inc | output | 1 | Second-increment strobe |

## Verification
A prescaler that is off by even one count shows up at the ports within one phase of the square wave. It appears as a wrong low or high length, or as a `sec_inc` that is not exactly SEC_PHASE ticks after the falling edge. A wrong reload on a seconds write shows up within one second, as a shifted next strobe. Flag faults show up on the cycle after the write or the event: a flag that is lost on a collision, or a flag that a write of 1 sets. A trim applied twice or at the wrong point changes the length of the low phase being measured.

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq #(
  parameter int PRE_W     = 15,
  parameter int SEC_PHASE = 3,
  parameter int ADJ_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mode_wr,
  input  logic [2:0]       mode_wdata,
  input  logic             sec_wr,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             min_edge,
  input  logic             hour_edge,
  input  logic             month_edge,
  input  logic             adj_stb,
  input  logic [ADJ_W-1:0] adj_delta,
  output logic             irq_n,
  output logic             flag,
  output logic             sec_inc
);
  localparam logic [PRE_W-1:0] FIRE_CNT = PRE_W'(SEC_PHASE - 1);
  localparam logic [PRE_W-1:0] LOAD_CNT = PRE_W'(SEC_PHASE);
  localparam logic [PRE_W-1:0] ADJ_CNT  = PRE_W'(1) << (PRE_W - 3);

  logic [2:0]       mode_q;
  logic [PRE_W-1:0] pre_q;
  logic [ADJ_W-1:0] adj_q;
  logic             adj_pend_q;
  logic             flag_q;
  logic             inc_q;
  logic             event_hit;

  wire fire      = tick_en && !sec_wr && (pre_q == FIRE_CNT);
  wire adj_apply = tick_en && !sec_wr && adj_pend_q && (pre_q == ADJ_CNT);
  wire set_flag  = fire && mode_q[2] && event_hit;
  wire clr_flag  = flag_wr && !flag_wdata;

  wire [PRE_W-1:0] adj_ext = {{(PRE_W-ADJ_W){adj_q[ADJ_W-1]}}, adj_q};
  wire [PRE_W-1:0] step    = adj_apply ? PRE_W'(1) + adj_ext : PRE_W'(1);

  always_comb begin
    case (mode_q[1:0])
      2'd0:    event_hit = 1'b1;
      2'd1:    event_hit = min_edge;
      2'd2:    event_hit = hour_edge;
      default: event_hit = month_edge;
    endcase
  end

  always_comb begin
    case (mode_q)
      3'b000:  irq_n = 1'b1;
      3'b001:  irq_n = 1'b0;
      3'b010:  irq_n = pre_q[PRE_W-2];
      3'b011:  irq_n = pre_q[PRE_W-1];
      default: irq_n = !flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 3'b000;
      pre_q      <= '0;
      adj_q      <= '0;
      adj_pend_q <= 1'b0;
      flag_q     <= 1'b0;
      inc_q      <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_wdata;
      if (sec_wr) pre_q <= LOAD_CNT;
      else if (tick_en) pre_q <= pre_q + step;
      if (adj_stb) begin
        adj_q      <= adj_delta;
        adj_pend_q <= 1'b1;
      end else if (adj_apply) begin
        adj_pend_q <= 1'b0;
      end
      if (set_flag) flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      inc_q <= fire;
    end
  end

  assign flag    = flag_q;
  assign sec_inc = inc_q;

  AST_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_inc |=> !sec_inc); // R5
  AST_PULSE_INC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b011) && sec_inc |-> !irq_n); // R5
  AST_LEVEL_FALL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[2] && $stable(mode_q) && $fell(irq_n) |-> sec_inc); // R6
  AST_FLAG_RISE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> sec_inc); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(flag_wr && !flag_wdata) |=> flag); // R8
  AST_SECWR_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> !sec_inc); // R10
endmodule

// File: tb/rtc_tick_irq_tb_top.sv
module rtc_tick_irq_tb_top;
  localparam int PRE_W = 8;
  localparam int SEC_PHASE = 3;
  localparam int ADJ_W = 6;
  localparam int PERIOD = 1 << PRE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, mode_wr = 1'b0, sec_wr = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [2:0] mode_wdata = '0;
  logic min_edge = 1'b0, hour_edge = 1'b0, month_edge = 1'b0, adj_stb = 1'b0;
  logic [ADJ_W-1:0] adj_delta = '0;
  logic irq_n, flag, sec_inc;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rtc_tick_irq #(.PRE_W(PRE_W), .SEC_PHASE(SEC_PHASE), .ADJ_W(ADJ_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .sec_wr(sec_wr), .flag_wr(flag_wr), .flag_wdata(flag_wdata), .min_edge(min_edge),
    .hour_edge(hour_edge), .month_edge(month_edge), .adj_stb(adj_stb), .adj_delta(adj_delta),
    .irq_n(irq_n), .flag(flag), .sec_inc(sec_inc));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic flag_write(input logic d);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = d;
    @(negedge clk); flag_wr = 1'b0;
  endtask

  task automatic wait_inc;
    @(negedge clk);
    while (!sec_inc) @(negedge clk);
  endtask

  task automatic measure(input logic lvl, output int n);
    while (irq_n == lvl) @(negedge clk);
    while (irq_n != lvl) @(negedge clk);
    n = 0;
    while (irq_n == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 flag", int'(flag), 0);
    chk("R1 sec_inc", int'(sec_inc), 0);
  endtask

  task automatic t_static;
    set_mode(3'b001);
    chk("R12 mode 001 effective", int'(irq_n), 0);
    wait_inc;
    chk("R2 mode 001 low", int'(irq_n), 0);
    chk("R2 mode 001 no flag", int'(flag), 0);
    set_mode(3'b000);
    wait_inc;
    chk("R2 mode 000 high", int'(irq_n), 1);
    chk("R2 mode 000 no flag", int'(flag), 0);
  endtask

  task automatic t_pulse;
    int n;
    set_mode(3'b010);
    measure(1'b0, n); chk("R3 2Hz low", n, PERIOD / 4);
    measure(1'b1, n); chk("R3 2Hz high", n, PERIOD / 4);
    set_mode(3'b011);
    measure(1'b0, n); chk("R4 1Hz low", n, PERIOD / 2);
    measure(1'b1, n); chk("R4 1Hz high", n, PERIOD / 2);
    while (irq_n) @(negedge clk);
    n = 0;
    while (!sec_inc) begin @(negedge clk); n++; end
    chk("R5 fall to inc", n, SEC_PHASE);
    @(negedge clk); chk("R5 strobe one cycle", int'(sec_inc), 0);
    n = 1;
    while (!sec_inc) begin @(negedge clk); n++; end
    chk("R5 inc spacing", n, PERIOD);
  endtask

  task automatic t_secwr;
    int n;
    while (!irq_n) @(negedge clk);
    repeat (10) @(negedge clk);
    sec_wr = 1'b1;
    @(negedge clk); sec_wr = 1'b0;
    chk("R10 irq low after write", int'(irq_n), 0);
    chk("R10 no inc after write", int'(sec_inc), 0);
    n = 0;
    while (!sec_inc) begin @(negedge clk); n++; end
    chk("R10 next inc", n, PERIOD);
  endtask

  task automatic t_level;
    set_mode(3'b100);
    flag_write(1'b0);
    wait_inc;
    chk("R6 flag at inc", int'(flag), 1);
    chk("R6 irq low at inc", int'(irq_n), 0);
    repeat (30) @(negedge clk);
    chk("R8 irq held low", int'(irq_n), 0);
    flag_write(1'b1);
    chk("R8 write 1 keeps set", int'(flag), 1);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    chk("R8 clear flag", int'(flag), 0);
    chk("R8 irq released", int'(irq_n), 1);
    flag_write(1'b1);
    chk("R8 write 1 ignored", int'(flag), 0);
  endtask

  task automatic t_collide;
    wait_inc;
    flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    chk("R8 clear before collide", int'(flag), 0);
    repeat (PERIOD - 2) @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    chk("R9 collide inc", int'(sec_inc), 1);
    chk("R9 collide keeps flag", int'(flag), 1);
    flag_write(1'b0);
  endtask

  task automatic t_qual(input logic [2:0] m, input string req);
    set_mode(m);
    flag_write(1'b0);
    min_edge = (m != 3'b101); hour_edge = (m != 3'b110); month_edge = (m != 3'b111);
    wait_inc;
    chk({req, " other qualifiers ignored"}, int'(flag), 0);
    chk({req, " irq idle"}, int'(irq_n), 1);
    @(negedge clk);
    min_edge = (m == 3'b101); hour_edge = (m == 3'b110); month_edge = (m == 3'b111);
    wait_inc;
    chk({req, " qualified event"}, int'(flag), 1);
    chk({req, " irq low"}, int'(irq_n), 0);
    min_edge = 1'b0; hour_edge = 1'b0; month_edge = 1'b0;
    flag_write(1'b0);
  endtask

  task automatic t_adjust;
    int n;
    set_mode(3'b011);
    while (!irq_n) @(negedge clk);
    @(negedge clk); adj_stb = 1'b1; adj_delta = ADJ_W'(10);
    @(negedge clk); adj_stb = 1'b0;
    measure(1'b0, n); chk("R11 shrink low", n, PERIOD / 2 - 10);
    @(negedge clk); adj_stb = 1'b1; adj_delta = ADJ_W'(-10);
    @(negedge clk); adj_stb = 1'b0;
    measure(1'b0, n); chk("R11 stretch low", n, PERIOD / 2 + 10);
    measure(1'b0, n); chk("R11 applied once", n, PERIOD / 2);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1; tick_en = 1'b1;
    t_static;
    t_pulse;
    t_secwr;
    t_level;
    t_collide;
    t_qual(3'b101, "R7 minute");
    t_qual(3'b110, "R7 hour");
    t_qual(3'b111, "R7 month");
    t_adjust;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule